// File: doc/BRIEF.md
# Grouped Write-Lock Register Bank

This block is a small register bank in which one lock word at offset zero carries one lock bit per group of configuration registers. While a group's lock bit is 1, software may write that group's registers. Software clears a bit by writing 0 to it. Writing 1 to a bit does nothing. Once a bit is 0, every write to that group's registers is dropped without a bus error. Reads keep returning the stored values. Reset puts every lock bit back to 1.

Each lock bit is independent. A per-group parameter selects how a bit is owned. A software-owned bit is cleared by a write of 0 to the lock word. A hardware-owned bit ignores software and is cleared only by a hardware pulse. In both modes a hardware set pulse returns the bit to 1 and opens the group again, for example after some operation completes.

The bus is a single-cycle request with these signals: valid, write, address, write data and byte strobes. A read returns its data one cycle later with a response valid flag.

Top module: `lkb_lockbank`

## Requirements
- R1: After reset every lock bit reads 1, every guarded register reads 0, and rsp_valid is 0.
- R2: A write to byte offset 0x0 with req_strb[0]=1 clears lock bit g when data bit g is 0. It leaves bit g unchanged when data bit g is 1. Each bit is handled on its own. If req_strb[0]=0, the write does not change the lock word.
- R3: While lock bit g is 0, writes to the registers of group g are discarded. Writes to other groups whose lock bit is 1 still take effect.
- R4: A read returns its data on the cycle after the request, with rsp_valid high for that one cycle. The data is as follows:
  - For offset 0x0: the lock bits in bits [N_GROUPS-1:0] and zeros above.
  - For a guarded register: its stored value, whether or not the register is locked.
  - For an unused offset, or an offset that is not word aligned: zero.
- R5: A write to a guarded register updates only the byte lanes whose req_strb bit is 1.
- R6: A pulse on hw_set[g] sets lock bit g to 1 on the next edge. It wins over a software clear of that bit in the same cycle.
- R7: A group selected in HW_OWNED ignores software writes to its lock bit and is cleared by hw_clr[g]. For any other group, hw_clr[g] has no effect.
- R8: Register k of group g is at byte offset 4 + 8*g + 4*k. With the default sizes, the six guarded registers are at 0x04 to 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_strb | input | DATA_W/8 | Byte-lane write strobes |
| hw_set | input | N_GROUPS | Hardware pulse that re-opens a group |
| hw_clr | input | N_GROUPS | Hardware pulse that locks a hardware-owned group |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |

## Verification
The assertions check these properties on every cycle:
- A locked group's registers stay unchanged.
- A lock bit follows its write-zero-to-clear rule and its ownership mode.
- A set pulse always opens the group.
- Every read gets exactly one response on the next cycle.

Only the bench scenarios can show that the right value reaches the right offset. They also show that byte-lane merging is correct, that unused and misaligned offsets read as zero, and that reset restores a bank after a sequence of locks and re-opens.

// File: rtl/lkb_pkg.sv
package lkb_pkg;

    // Kind of target selected by an address.
    typedef enum logic [1:0] {
        DEC_NONE  = 2'd0,
        DEC_LOCK  = 2'd1,
        DEC_GUARD = 2'd2
    } dec_kind_e;

endpackage

// File: rtl/lkb_lock_field.sv
module lkb_lock_field #(
    parameter bit HW_OWNED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_wr,
    input  logic sw_bit,
    input  logic hw_set,
    input  logic hw_clr,
    output logic en_o
);

    typedef struct packed {
        logic en;
    } field_t;

    field_t fld_d, fld_q;

    always_comb begin
        fld_d = fld_q;
        if (hw_set) begin
            fld_d.en = 1'b1;
        end else if (HW_OWNED) begin
            if (hw_clr) fld_d.en = 1'b0;
        end else if (sw_wr && !sw_bit) begin
            fld_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fld_q <= '{en: 1'b1};
        else        fld_q <= fld_d;
    end

    assign en_o = fld_q.en;

endmodule

// File: rtl/lkb_guard_reg.sv
module lkb_guard_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic              wr_allow,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic [DATA_W-1:0] q_o
);

    localparam int STRB_W = DATA_W / 8;

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } greg_t;

    greg_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        for (int b = 0; b < STRB_W; b++) begin
            if (wr_hit && wr_allow && wstrb[b]) begin
                reg_d.val[b*8 +: 8] = wdata[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    assign q_o = reg_q.val;

endmodule

// File: rtl/lkb_lockbank.sv
module lkb_lockbank #(
    parameter int                N_GROUPS       = 3,
    parameter int                REGS_PER_GROUP = 2,
    parameter int                DATA_W         = 32,
    parameter int                ADDR_W         = 8,
    parameter logic [N_GROUPS-1:0] HW_OWNED     = 3'b100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_strb,
    input  logic [N_GROUPS-1:0]   hw_set,
    input  logic [N_GROUPS-1:0]   hw_clr,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata
);

    import lkb_pkg::*;

    localparam int N_REGS  = N_GROUPS * REGS_PER_GROUP;
    localparam int STRB_W  = DATA_W / 8;
    localparam int OFF_LSB = $clog2(STRB_W);
    localparam int IDX_W   = ADDR_W - OFF_LSB;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_t;

    logic [IDX_W-1:0]        word_idx;
    logic                    aligned;
    logic                    is_wr;
    logic                    lock_wr;
    dec_kind_e               kind;
    logic [N_GROUPS-1:0]     lock_en;
    logic [N_REGS-1:0]       reg_wr;
    logic [DATA_W-1:0]       regs_q [N_REGS];
    logic [N_REGS*DATA_W-1:0] regs_flat;
    logic [DATA_W-1:0]       rd_sel;
    rsp_t                    rsp_d, rsp_q;

    // Address decode
    always_comb begin
        word_idx = req_addr[ADDR_W-1:OFF_LSB];
        aligned  = (req_addr[OFF_LSB-1:0] == '0);
        if (!aligned)                              kind = DEC_NONE;
        else if (word_idx == '0)                   kind = DEC_LOCK;
        else if (int'(word_idx) <= N_REGS)         kind = DEC_GUARD;
        else                                       kind = DEC_NONE;
        is_wr   = req_valid && req_write;
        lock_wr = is_wr && (kind == DEC_LOCK) && req_strb[0];
    end

    // One lock bit per group
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_lock
        lkb_lock_field #(.HW_OWNED(HW_OWNED[g])) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .sw_wr  (lock_wr),
            .sw_bit (req_wdata[g]),
            .hw_set (hw_set[g]),
            .hw_clr (hw_clr[g]),
            .en_o   (lock_en[g])
        );
    end

    // Guarded registers, each one in exactly one group
    for (genvar i = 0; i < N_REGS; i++) begin : g_reg
        localparam int GRP = i / REGS_PER_GROUP;
        assign reg_wr[i] = is_wr && (kind == DEC_GUARD) && (word_idx == IDX_W'(i + 1));
        lkb_guard_reg #(.DATA_W(DATA_W)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (reg_wr[i]),
            .wr_allow (lock_en[GRP]),
            .wdata    (req_wdata),
            .wstrb    (req_strb),
            .q_o      (regs_q[i])
        );
        assign regs_flat[i*DATA_W +: DATA_W] = regs_q[i];
    end

    // Read path, registered
    always_comb begin
        rd_sel = '0;
        case (kind)
            DEC_LOCK:  rd_sel = DATA_W'(lock_en);
            DEC_GUARD: begin
                for (int i = 0; i < N_REGS; i++) begin
                    if (word_idx == IDX_W'(i + 1)) rd_sel = regs_q[i];
                end
            end
            default:   rd_sel = '0;
        endcase
        rsp_d.valid = req_valid && !req_write;
        rsp_d.data  = rsp_d.valid ? rd_sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

endmodule

// File: rtl/lkb_lockbank_chk.sv
module lkb_lockbank_chk #(
    parameter int                  N_GROUPS       = 3,
    parameter int                  REGS_PER_GROUP = 2,
    parameter int                  DATA_W         = 32,
    parameter int                  ADDR_W         = 8,
    parameter logic [N_GROUPS-1:0] HW_OWNED       = 3'b100
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 req_valid,
    input logic                                 req_write,
    input logic [ADDR_W-1:0]                    req_addr,
    input logic [DATA_W-1:0]                    req_wdata,
    input logic [DATA_W/8-1:0]                  req_strb,
    input logic [N_GROUPS-1:0]                  hw_set,
    input logic [N_GROUPS-1:0]                  hw_clr,
    input logic                                 rsp_valid,
    input logic [N_GROUPS-1:0]                  lock_en,
    input logic [N_GROUPS*REGS_PER_GROUP*DATA_W-1:0] regs_flat
);

    logic lock_word_wr;
    assign lock_word_wr = req_valid && req_write && (req_addr == '0) && req_strb[0];

    // R4: one response on the cycle after each read, none otherwise
    a_r4_read_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        // R6: set pulse always opens the group
        a_r6_hw_set: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[g] |=> lock_en[g]);

        if (HW_OWNED[g]) begin : g_hw
            // R7: software cannot move a hardware-owned bit
            a_r7_sw_ignored: assert property (@(posedge clk) disable iff (!rst_n)
                (!hw_set[g] && !hw_clr[g]) |=> $stable(lock_en[g]));
            a_r7_hw_clr: assert property (@(posedge clk) disable iff (!rst_n)
                (hw_clr[g] && !hw_set[g]) |=> !lock_en[g]);
        end else begin : g_sw
            // R2: write zero clears, write one keeps
            a_r2_w0_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (lock_word_wr && !req_wdata[g] && !hw_set[g]) |=> !lock_en[g]);
            a_r2_w1_keeps: assert property (@(posedge clk) disable iff (!rst_n)
                (!(lock_word_wr && !req_wdata[g]) && !hw_set[g]) |=> $stable(lock_en[g]));
        end

        for (genvar k = 0; k < REGS_PER_GROUP; k++) begin : g_r
            localparam int IX = g * REGS_PER_GROUP + k;
            // R3: locked group registers never change
            a_r3_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
                !lock_en[g] |=> $stable(regs_flat[IX*DATA_W +: DATA_W]));
        end
    end

endmodule

bind lkb_lockbank lkb_lockbank_chk #(
    .N_GROUPS       (N_GROUPS),
    .REGS_PER_GROUP (REGS_PER_GROUP),
    .DATA_W         (DATA_W),
    .ADDR_W         (ADDR_W),
    .HW_OWNED       (HW_OWNED)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_strb  (req_strb),
    .hw_set    (hw_set),
    .hw_clr    (hw_clr),
    .rsp_valid (rsp_valid),
    .lock_en   (lock_en),
    .regs_flat (regs_flat)
);

// File: tb/sim_lkb_lockbank.sv
module sim_lkb_lockbank;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_strb = '0;
    logic [2:0]  hw_set = '0;
    logic [2:0]  hw_clr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] mdl_regs [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    lkb_lockbank u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .hw_set(hw_set), .hw_clr(hw_clr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NREG; i++) mdl_regs[i] = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                      input logic [2:0] set_p = '0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_strb = s;
        hw_set = set_p;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; hw_set = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rsp_rdata;
        v = rsp_valid;
    endtask

    task automatic hw_pulse(input logic [2:0] s, input logic [2:0] c);
        @(negedge clk);
        hw_set = s; hw_clr = c;
        @(negedge clk);
        hw_set = '0; hw_clr = '0;
    endtask

    // Model write applied only when the bench expects the lock open.
    function automatic void mdl_wr(input int idx, input logic [31:0] d, input logic [3:0] s);
        for (int b = 0; b < 4; b++) if (s[b]) mdl_regs[idx][b*8 +: 8] = d[b*8 +: 8];
    endfunction

    function automatic logic [7:0] off(input int idx);
        return 8'(4 + 4 * idx); // R8 map
    endfunction

    task automatic check_all_regs(input string tag);
        logic [31:0] d; logic v;
        for (int i = 0; i < NREG; i++) begin
            rd(off(i), d, v);
            chk(tag, d, mdl_regs[i]);
        end
    endtask

    task automatic t_reset();
        logic [31:0] d; logic v;
        do_reset();
        chk("R1 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
        rd(8'h00, d, v);
        chk("R1 lock after reset", d, 32'h7);
        chk("R4 read rsp_valid", {31'b0, v}, 32'h1);
        check_all_regs("R1 guarded reset value");
    endtask

    task automatic t_map();
        logic [31:0] d; logic v;
        for (int i = 0; i < NREG; i++) begin
            wr(off(i), 32'hA500_0000 + 32'(i * 17), 4'hF);
            mdl_wr(i, 32'hA500_0000 + 32'(i * 17), 4'hF);
        end
        check_all_regs("R8 map readback");
        rd(8'h1C, d, v); chk("R4 unused offset", d, 32'h0);
        rd(8'h40, d, v); chk("R4 far unused offset", d, 32'h0);
        rd(8'h05, d, v); chk("R4 misaligned", d, 32'h0);
        wr(8'h1C, 32'hFFFF_FFFF, 4'hF);
        check_all_regs("R8 unused write no alias");
    endtask

    task automatic t_strobe();
        wr(off(1), 32'h1122_3344, 4'b0101);
        mdl_wr(1, 32'h1122_3344, 4'b0101);
        wr(off(3), 32'hDEAD_BEEF, 4'b1000);
        mdl_wr(3, 32'hDEAD_BEEF, 4'b1000);
        check_all_regs("R5 byte strobes");
    endtask

    task automatic t_w0c();
        logic [31:0] d; logic v;
        wr(8'h00, 32'h0, 4'b0010);
        rd(8'h00, d, v); chk("R2 no strobe0 ignored", d, 32'h7);
        wr(8'h00, 32'hFFFF_FFFE, 4'h1);
        rd(8'h00, d, v); chk("R2 clear bit0 only", d, 32'h6);
        wr(8'h00, 32'hFFFF_FFFF, 4'h1);
        rd(8'h00, d, v); chk("R2 write one keeps", d, 32'h6);
        wr(off(0), 32'h0BAD_0BAD, 4'hF);   // group 0 locked: dropped
        wr(off(2), 32'h0600_D000, 4'hF);   // group 1 open
        mdl_wr(2, 32'h0600_D000, 4'hF);
        check_all_regs("R3 locked group writes dropped");
        wr(8'h00, 32'h0, 4'h1);
        rd(8'h00, d, v); chk("R7 sw clear of hw-owned bit ignored", d, 32'h4);
        wr(off(2), 32'h1, 4'hF);
        check_all_regs("R3 group1 now locked");
    endtask

    task automatic t_hw();
        logic [31:0] d; logic v;
        hw_pulse(3'b000, 3'b011);
        rd(8'h00, d, v); chk("R7 hw_clr no effect on sw-owned", d, 32'h4);
        hw_pulse(3'b000, 3'b100);
        rd(8'h00, d, v); chk("R7 hw_clr clears hw-owned", d, 32'h0);
        wr(off(4), 32'h5555_5555, 4'hF);
        check_all_regs("R3 hw-locked group dropped");
        wr(8'h00, 32'h0, 4'h1, 3'b001);
        rd(8'h00, d, v); chk("R6 set wins over sw clear", d, 32'h1);
        wr(off(0), 32'hCAFE_0001, 4'hF);
        mdl_wr(0, 32'hCAFE_0001, 4'hF);
        hw_pulse(3'b100, 3'b000);
        rd(8'h00, d, v); chk("R6 hw_set reopens", d, 32'h5);
        wr(off(5), 32'h7777_0000, 4'b1100);
        mdl_wr(5, 32'h7777_0000, 4'b1100);
        check_all_regs("R6 reopened groups writable");
        hw_pulse(3'b000, 3'b001);
        rd(8'h00, d, v); chk("R7 hw_clr ignored on sw bit", d, 32'h5);
    endtask

    task automatic t_reset_again();
        logic [31:0] d; logic v;
        do_reset();
        rd(8'h00, d, v); chk("R1 lock restored by reset", d, 32'h7);
        check_all_regs("R1 regs cleared by reset");
        wr(off(0), 32'h0000_00AB, 4'h1);
        mdl_wr(0, 32'h0000_00AB, 4'h1);
        check_all_regs("R1 access restored");
    endtask

    initial begin
        t_reset();
        t_map();
        t_strobe();
        t_w0c();
        t_hw();
        t_reset_again();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule